// File: doc/BRIEF.md
# Multichannel SPI Interrupt Status Controller

This block gathers single-cycle event pulses from the transmit and receive logic of four SPI channels into one status register. Each channel reports three events: transmit holding space available, transmit underflow and receive data full. A fourth kind of event, the end of a programmed word count, is reported once for the whole block. Each status bit latches when its pulse arrives and stays set until software writes a one to it. Status bits latch whether or not they are enabled, so software can run the block by polling alone.

An enable register holds one mask bit at the same position as each status bit. The single level interrupt line is the OR of every status bit that is both set and enabled, taken through one register stage. If an event has already latched and its enable is then cleared, the line drops, even though the event is still unserviced. The line stays high until software clears the enabled bit; a channel that removes the cause of an event does not lower the line.

Both registers are written through one simple write port. A select input picks the target: status (write-one-to-clear) or enable (plain overwrite). Both registers are presented continuously on output ports for reading.

Top module: `spi_irq_status_ctrl`

## Requirements
- R1: After reset, the status register, the enable register and the interrupt line are all zero.
- R2: A pulse on a channel event input sets one status bit at the next clock edge. For channel c, transmit-empty sets bit 4c, transmit-underflow sets bit 4c+1 and receive-full sets bit 4c+2. A pulse on the word-count-done input sets bit 17. With default parameters the implemented bits form the mask 0x0002_7777.
- R3: Status bits latch and read back with every enable bit at zero, and the interrupt line then stays low.
- R4: A write with `wr_sel`=0 clears exactly the status bits where `wr_data` holds a one. Status bits where `wr_data` holds a zero keep their value.
- R5: If an event pulse and a clear of the same status bit occur in the same cycle, the bit is set after that edge.
- R6: A write with `wr_sel`=1 replaces the enable register with `wr_data`, limited to the implemented bit positions of R2.
- R7: The interrupt line equals, one clock later, the OR over all bits of status AND enable.
- R8: Clearing the enable of a latched status bit lowers the interrupt line one cycle later. The status bit stays set.
- R9: A latched, enabled status bit holds the interrupt line high for as many cycles as software leaves it uncleared, with no further event pulses.
- R10: Status and enable bits outside the mask 0x0002_7777 always read zero, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_empty | input | NUM_CH | Per-channel transmit-space-available pulse |
| ev_tx_underflow | input | NUM_CH | Per-channel transmit-underflow pulse |
| ev_rx_full | input | NUM_CH | Per-channel receive-full pulse |
| ev_word_count_done | input | 1 | End of programmed word count pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write one to clear), 1 enable |
| wr_data | input | REG_W | Write data |
| status_q | output | REG_W | Current status register |
| enable_q | output | REG_W | Current enable register |
| irq | output | 1 | Level interrupt line |

## Verification
The bound checker watches every cycle for the following: pulses latching into their bits, set winning over a same-cycle clear, clears reaching only the selected bits, latched bits holding, enable writes landing, reserved bits staying zero, and the interrupt line following masked status with a one-cycle lag. Only the bench's scenarios can show the behaviour over a sequence: a polled event that never raises the line, a mask applied after latching that silences an unserviced event, a line held high over many idle cycles, and the exact bit positions of each channel's events against the fixed layout.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   // Bit slots inside one channel's nibble of the status register.
   localparam int SLOT_TX_EMPTY = 0;
   localparam int SLOT_TX_UNDER = 1;
   localparam int SLOT_RX_FULL  = 2;
   localparam int SLOT_W        = 4;

   // Mask of implemented status/enable positions for a given channel count.
   function automatic logic [63:0] build_valid_mask(int num_ch, int eow_bit);
      logic [63:0] m;
      m = '0;
      for (int c = 0; c < num_ch; c++) begin
         m[SLOT_W*c + SLOT_TX_EMPTY] = 1'b1;
         m[SLOT_W*c + SLOT_TX_UNDER] = 1'b1;
         m[SLOT_W*c + SLOT_RX_FULL]  = 1'b1;
      end
      m[eow_bit] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/spi_irq_event_map.sv
module spi_irq_event_map
   import spi_irq_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int REG_W   = 32,
   parameter int EOW_BIT = 17
) (
   input  logic [NUM_CH-1:0] ev_tx_empty,
   input  logic [NUM_CH-1:0] ev_tx_underflow,
   input  logic [NUM_CH-1:0] ev_rx_full,
   input  logic              ev_word_count_done,
   output logic [REG_W-1:0]  set_vec
);

   // Per-channel event lanes placed into their nibble.
   logic [REG_W-1:0] lane_bits [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      always_comb begin
         lane_bits[c] = '0;
         lane_bits[c][SLOT_W*c + SLOT_TX_EMPTY] = ev_tx_empty[c];
         lane_bits[c][SLOT_W*c + SLOT_TX_UNDER] = ev_tx_underflow[c];
         lane_bits[c][SLOT_W*c + SLOT_RX_FULL]  = ev_rx_full[c];
      end
   end

   always_comb begin
      set_vec = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         set_vec = set_vec | lane_bits[c];
      end
      set_vec[EOW_BIT] = ev_word_count_done;
   end

endmodule

// File: rtl/spi_irq_status_bank.sv
module spi_irq_status_bank #(
   parameter int               REG_W      = 32,
   parameter logic [REG_W-1:0] VALID_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic [REG_W-1:0] clr_vec,
   output logic [REG_W-1:0] status_q
);

   logic [REG_W-1:0] status_d;

   // Set has priority over a write-one clear in the same cycle.
   always_comb begin
      status_d = ((status_q & ~clr_vec) | set_vec) & VALID_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= status_d;
      end
   end

endmodule

// File: rtl/spi_irq_enable_bank.sv
module spi_irq_enable_bank #(
   parameter int               REG_W      = 32,
   parameter logic [REG_W-1:0] VALID_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] enable_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (wr_stb) begin
         enable_q <= wr_data & VALID_MASK;
      end
   end

endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] status_q,
   input  logic [REG_W-1:0] enable_q,
   output logic             irq
);

   logic pending;

   always_comb begin
      pending = |(status_q & enable_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else begin
         irq <= pending;
      end
   end

endmodule

// File: rtl/spi_irq_status_ctrl.sv
module spi_irq_status_ctrl
   import spi_irq_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int REG_W   = 32,
   parameter int EOW_BIT = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ev_tx_empty,
   input  logic [NUM_CH-1:0] ev_tx_underflow,
   input  logic [NUM_CH-1:0] ev_rx_full,
   input  logic              ev_word_count_done,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  status_q,
   output logic [REG_W-1:0]  enable_q,
   output logic              irq
);

   localparam logic [63:0]      MASK_WIDE  = build_valid_mask(NUM_CH, EOW_BIT);
   localparam logic [REG_W-1:0] VALID_MASK = MASK_WIDE[REG_W-1:0];

   // Elaboration-time parameter checks.
   if (NUM_CH < 1) begin : g_bad_nch
      $error("spi_irq_status_ctrl: NUM_CH must be at least 1");
   end
   if (SLOT_W*NUM_CH > EOW_BIT) begin : g_bad_overlap
      $error("spi_irq_status_ctrl: channel bits overlap the word-count bit");
   end
   if (EOW_BIT >= REG_W) begin : g_bad_eow
      $error("spi_irq_status_ctrl: EOW_BIT outside the register");
   end
   if (REG_W > 64) begin : g_bad_w
      $error("spi_irq_status_ctrl: REG_W above 64");
   end

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;
   logic             en_stb;

   always_comb begin
      clr_vec = (wr_en && !wr_sel) ? wr_data : '0;
      en_stb  = wr_en && wr_sel;
   end

   spi_irq_event_map #(
      .NUM_CH  (NUM_CH),
      .REG_W   (REG_W),
      .EOW_BIT (EOW_BIT)
   ) u_map (
      .ev_tx_empty        (ev_tx_empty),
      .ev_tx_underflow    (ev_tx_underflow),
      .ev_rx_full         (ev_rx_full),
      .ev_word_count_done (ev_word_count_done),
      .set_vec            (set_vec)
   );

   spi_irq_status_bank #(
      .REG_W      (REG_W),
      .VALID_MASK (VALID_MASK)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec),
      .status_q (status_q)
   );

   spi_irq_enable_bank #(
      .REG_W      (REG_W),
      .VALID_MASK (VALID_MASK)
   ) u_enable (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (en_stb),
      .wr_data  (wr_data),
      .enable_q (enable_q)
   );

   spi_irq_line #(
      .REG_W (REG_W)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_q (status_q),
      .enable_q (enable_q),
      .irq      (irq)
   );

endmodule

// File: rtl/spi_irq_status_ctrl_chk.sv
module spi_irq_status_ctrl_chk
   import spi_irq_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int REG_W   = 32,
   parameter int EOW_BIT = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ev_tx_empty,
   input logic [NUM_CH-1:0] ev_tx_underflow,
   input logic [NUM_CH-1:0] ev_rx_full,
   input logic              ev_word_count_done,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  status_q,
   input logic [REG_W-1:0]  enable_q,
   input logic              irq
);

   localparam logic [63:0]      CHK_WIDE = build_valid_mask(NUM_CH, EOW_BIT);
   localparam logic [REG_W-1:0] CHK_MASK = CHK_WIDE[REG_W-1:0];

   // Which bits an event pulse targets this cycle, per the bit layout.
   logic [REG_W-1:0] hit;
   logic [REG_W-1:0] wipe;

   always_comb begin
      hit = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ev_tx_empty[c])     hit[4*c]     = 1'b1;
         if (ev_tx_underflow[c]) hit[4*c + 1] = 1'b1;
         if (ev_rx_full[c])      hit[4*c + 2] = 1'b1;
      end
      if (ev_word_count_done) hit[EOW_BIT] = 1'b1;
      wipe = (wr_en && !wr_sel) ? wr_data : '0;
   end

   // R1: registers and line are empty in the first cycle out of reset.
   a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (status_q == '0 && enable_q == '0 && !irq));

   // R10: unimplemented positions never read as one.
   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q | enable_q) & ~CHK_MASK) == '0);

   // R6: an enable write lands at the next edge.
   a_r6_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (enable_q == ($past(wr_data) & CHK_MASK)));

   // R7: the line trails masked status by one cycle.
   a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(status_q & enable_q)));

   // R8: nothing enabled and pending means the line is low next cycle.
   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & enable_q) == '0) |=> !irq);

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (CHK_MASK[b]) begin : g_live
         // R2: a pulse latches its bit.
         a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
            hit[b] |=> status_q[b]);
         // R5: set beats a simultaneous clear.
         a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[b] && wipe[b]) |=> status_q[b]);
         // R4: a write-one clear removes the bit when no pulse competes.
         a_r4_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
            (wipe[b] && !hit[b]) |=> !status_q[b]);
         // R9: an uncleared bit holds.
         a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[b] && !wipe[b]) |=> status_q[b]);
      end
   end

endmodule

bind spi_irq_status_ctrl spi_irq_status_ctrl_chk #(
   .NUM_CH  (NUM_CH),
   .REG_W   (REG_W),
   .EOW_BIT (EOW_BIT)
) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .ev_tx_empty        (ev_tx_empty),
   .ev_tx_underflow    (ev_tx_underflow),
   .ev_rx_full         (ev_rx_full),
   .ev_word_count_done (ev_word_count_done),
   .wr_en              (wr_en),
   .wr_sel             (wr_sel),
   .wr_data            (wr_data),
   .status_q           (status_q),
   .enable_q           (enable_q),
   .irq                (irq)
);

// File: tb/spi_irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module spi_irq_status_ctrl_bench;

   localparam logic [31:0] LEGAL = 32'h0002_7777;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ev_te = '0;
   logic [3:0]  ev_tu = '0;
   logic [3:0]  ev_rf = '0;
   logic        ev_wc = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] status_q;
   logic [31:0] enable_q;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   spi_irq_status_ctrl u_spi_irq_status_ctrl (
      .clk                (clk),
      .rst_n              (rst_n),
      .ev_tx_empty        (ev_te),
      .ev_tx_underflow    (ev_tu),
      .ev_rx_full         (ev_rf),
      .ev_word_count_done (ev_wc),
      .wr_en              (wr_en),
      .wr_sel             (wr_sel),
      .wr_data            (wr_data),
      .status_q           (status_q),
      .enable_q           (enable_q),
      .irq                (irq)
   );

   // Behavioural reference, updated at each rising edge.
   bit [31:0] m_stat = '0;
   bit [31:0] m_en = '0;
   bit        m_irq = 1'b0;

   always @(posedge clk) begin
      bit [31:0] s;
      bit        nxt;
      if (!rst_n) begin
         m_stat = '0; m_en = '0; m_irq = 1'b0;
      end else begin
         nxt = (m_stat & m_en) != 0;
         s = '0;
         for (int c = 0; c < 4; c++) begin
            if (ev_te[c]) s[4*c] = 1'b1;
            if (ev_tu[c]) s[4*c+1] = 1'b1;
            if (ev_rf[c]) s[4*c+2] = 1'b1;
         end
         if (ev_wc) s[17] = 1'b1;
         if (wr_en && !wr_sel) m_stat = m_stat & ~wr_data;
         m_stat = (m_stat | s) & LEGAL;
         if (wr_en && wr_sel) m_en = wr_data & LEGAL;
         m_irq = nxt;
      end
   end

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   // Every-cycle comparison with the model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2", "status vs model", status_q, m_stat);
         check("R6", "enable vs model", enable_q, m_en);
         check("R7", "irq vs model", {31'd0, irq}, {31'd0, m_irq});
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic quiet();
      ev_te = '0; ev_tu = '0; ev_rf = '0; ev_wc = 1'b0;
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
   endtask

   task automatic write_reg(logic sel, logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step();
      quiet();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      quiet();
      repeat (3) step();
      rst_n = 1'b1;
      step();
      check("R1", "status after reset", status_q, 32'h0);
      check("R1", "enable after reset", enable_q, 32'h0);
      check("R1", "irq after reset", {31'd0, irq}, 32'h0);

      // Polling: rx-full on channel 2 latches at bit 10 with no enables.
      ev_rf = 4'b0100; step(); quiet();
      check("R3", "polled status", status_q, 32'h0000_0400);
      step();
      check("R3", "line low with enables off", {31'd0, irq}, 32'h0);

      // Enable everything: only legal bits stick, line follows a cycle later.
      write_reg(1'b1, 32'hFFFF_FFFF);
      check("R10", "enable reserved bits", enable_q, LEGAL);
      check("R7", "line not yet high", {31'd0, irq}, 32'h0);
      step();
      check("R7", "line high one cycle later", {31'd0, irq}, 32'h1);

      // Mask after latch: line drops, status stays.
      write_reg(1'b1, 32'h0);
      check("R7", "line still high in lag cycle", {31'd0, irq}, 32'h1);
      step();
      check("R8", "masked line low", {31'd0, irq}, 32'h0);
      check("R8", "masked status kept", status_q, 32'h0000_0400);

      // Re-enable and hold with no further pulses.
      write_reg(1'b1, 32'h0000_0400);
      step();
      repeat (6) step();
      check("R9", "line held while uncleared", {31'd0, irq}, 32'h1);

      // Selective write-one clears.
      ev_te = 4'b0001; ev_wc = 1'b1; step(); quiet();
      check("R2", "tx-empty ch0 and word-count bits", status_q, 32'h0002_0401);
      write_reg(1'b0, 32'h0000_0001);
      check("R4", "clear bit 0 only", status_q, 32'h0002_0400);
      write_reg(1'b0, 32'h0000_0400);
      check("R4", "clear bit 10 only", status_q, 32'h0002_0000);
      step();
      check("R4", "line low after clear", {31'd0, irq}, 32'h0);

      // Set and clear of bit 13 (underflow ch3) in the same cycle.
      ev_tu = 4'b1000; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_2000;
      step(); quiet();
      check("R5", "set wins over clear", status_q, 32'h0002_2000);

      // Reserved-bit writes to status do nothing.
      write_reg(1'b0, 32'hFFFF_FFFF);
      check("R4", "clear all", status_q, 32'h0);
      write_reg(1'b0, ~LEGAL);
      check("R10", "reserved status write", status_q, 32'h0);

      // All events at once map onto the full legal mask.
      ev_te = 4'hF; ev_tu = 4'hF; ev_rf = 4'hF; ev_wc = 1'b1; step(); quiet();
      check("R2", "all events", status_q, LEGAL);
      write_reg(1'b0, 32'hFFFF_FFFF);

      // Random traffic against the model.
      for (int i = 0; i < 600; i++) begin
         ev_te = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
         ev_tu = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
         ev_rf = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
         ev_wc = ($urandom_range(0, 9) == 0);
         wr_en = ($urandom_range(0, 2) == 0);
         wr_sel = ($urandom_range(0, 3) == 0);
         wr_data = $urandom();
         step();
      end
      quiet();
      step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule